// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between a small 8-bit core and its data memory. The core presents an 8-bit direct address with read and write strobes. An 8-bit bank register decides where the access lands. Its low nibble picks one of several peripheral register banks, which appear in a narrow window at 10h–17h. Its high nibble picks one of several general-purpose RAM banks, which appear in the window 20h–FFh. The remaining low addresses (00h–0Fh and 18h–1Fh) reach a single set of common registers, whatever the bank register holds.

The core changes banks through two load operations. One replaces only the low nibble and the other replaces only the high nibble. Banks that are not built read as 00h, drop writes, and raise an "unimplemented" flag. Peripheral bank 15 is reserved. Reading it returns a fixed pattern and raises a separate "reserved" flag. Peripheral banks are modelled as plain storage.

Reads are combinational from the address and the current bank register. Writes and bank loads take effect on the rising clock edge.

Top module: `bank_mem_front`

## Requirements
- R1: After reset the bank register, visible on `bsr_q`, holds 00h.
- R2: `ld_sfr_en` loads `bank_nib` into `bsr_q[3:0]` at the clock edge and leaves `bsr_q[7:4]` unchanged. When `ld_gpr_en` is asserted in the same cycle, both nibbles take `bank_nib`.
- R3: `ld_gpr_en` loads `bank_nib` into `bsr_q[7:4]` at the clock edge and leaves `bsr_q[3:0]` unchanged.
- R4: Addresses 00h–0Fh and 18h–1Fh reach the same common storage for every bank register value.
- R5: Addresses 10h–17h reach the peripheral bank numbered by `bsr_q[3:0]`. Each implemented bank has its own storage.
- R6: Addresses 20h–FFh reach the RAM bank numbered by `bsr_q[7:4]`. Each implemented bank has its own storage.
- R7: Peripheral banks 0–7 are always implemented. Bank 8 is implemented only when `HAS_SFR_BANK8` is 1 (default 1). Accessing an unimplemented peripheral bank (9–14, or 8 when absent) reads 00h, discards the write and sets `unimpl_hit`.
- R8: RAM bank b is implemented only when b < `GPR_BANKS` (default 8) and bit b of `GPR_IMPL_MASK` is 1 (default F7h, so bank 3 is absent). Accessing any other RAM bank reads 00h, discards the write and sets `unimpl_hit`.
- R9: Peripheral bank 15 is reserved. A read there returns `RSVD_PATTERN` (default A5h) and a write there is discarded. Both raise `rsvd_hit` with `unimpl_hit` low.
- R10: `rdata` is 00h while `rd_en` is low. Both flags are low unless `rd_en` or `wr_en` is high. An access in the same cycle as a bank load uses the bank register value from before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the bank register |
| addr | input | 8 | Direct data address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| ld_sfr_en | input | 1 | Load `bank_nib` into the peripheral-bank nibble |
| ld_gpr_en | input | 1 | Load `bank_nib` into the RAM-bank nibble |
| bank_nib | input | 4 | Nibble value for bank loads |
| rdata | output | 8 | Read data (combinational) |
| unimpl_hit | output | 1 | Current access targets an unimplemented bank |
| rsvd_hit | output | 1 | Current access targets reserved peripheral bank 15 |
| bsr_q | output | 8 | Current bank register value |

## Verification
The peripheral window is tried with a different value written to the same offset in every bank from 0 to 8. This shows that each bank has its own storage and would reveal a nibble that is ignored or aliased. The RAM window is tried at its lowest and highest offsets in every bank, which separates offset arithmetic errors from bank selection errors. Writes to the unimplemented banks 9–14, to reserved bank 15 and to RAM bank 3 and banks 8–15 are followed by reads of the neighbouring implemented banks, to show that nothing was written through an alias. The common registers are read back under an all-ones bank register, and a write issued in the same cycle as a bank load shows which bank value the access used.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  typedef enum logic [1:0] {
    RG_COMMON = 2'd0,
    RG_SFR    = 2'd1,
    RG_GPR    = 2'd2
  } region_e;

  localparam logic [7:0] SFR_LO  = 8'h10;
  localparam logic [7:0] SFR_HI  = 8'h17;
  localparam logic [7:0] GPR_LO  = 8'h20;
  localparam int         GPR_SZ  = 256 - 32;
  localparam int         SFR_SZ  = 8;
  localparam logic [3:0] RSVD_BANK = 4'd15;

  function automatic region_e region_of(input logic [7:0] a);
    if (a >= GPR_LO)                  return RG_GPR;
    else if (a >= SFR_LO && a <= SFR_HI) return RG_SFR;
    else                              return RG_COMMON;
  endfunction

  function automatic logic sfr_bank_built(input logic [3:0] b, input bit has8);
    return (b < 4'd8) || (has8 && b == 4'd8);
  endfunction

  function automatic logic gpr_bank_built(input logic [3:0] b, input int nb,
                                          input logic [15:0] mask);
    return (int'(b) < nb) && mask[b];
  endfunction

endpackage

// File: rtl/bmf_bsr.sv
module bmf_bsr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_lo,
  input  logic       ld_hi,
  input  logic [3:0] nib,
  output logic [7:0] bsr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bsr <= 8'h00;
    else begin
      if (ld_lo) bsr[3:0] <= nib;
      if (ld_hi) bsr[7:4] <= nib;
    end
  end
endmodule

// File: rtl/bmf_decode.sv
module bmf_decode
  import bmf_pkg::*;
#(
  parameter bit          HAS_SFR_BANK8 = 1'b1,
  parameter int          GPR_BANKS     = 8,
  parameter logic [15:0] GPR_IMPL_MASK = 16'h00F7
) (
  input  logic [7:0] addr,
  input  logic [7:0] bsr,
  input  logic       access,
  output region_e    region,
  output logic [3:0] bank,
  output logic       acc_ok,
  output logic       unimpl,
  output logic       rsvd
);
  logic built;

  always_comb begin
    region = region_of(addr);
    bank   = 4'd0;
    built  = 1'b1;
    rsvd   = 1'b0;
    unique case (region)
      RG_SFR: begin
        bank  = bsr[3:0];
        rsvd  = (bank == RSVD_BANK);
        built = sfr_bank_built(bank, HAS_SFR_BANK8);
      end
      RG_GPR: begin
        bank  = bsr[7:4];
        built = gpr_bank_built(bank, GPR_BANKS, GPR_IMPL_MASK);
      end
      default: ;
    endcase
    acc_ok = built;
    unimpl = access & ~built & ~rsvd;
    rsvd   = access & rsvd;
  end
endmodule

// File: rtl/bmf_store.sv
module bmf_store
  import bmf_pkg::*;
#(
  parameter bit          HAS_SFR_BANK8 = 1'b1,
  parameter int          GPR_BANKS     = 8,
  parameter logic [15:0] GPR_IMPL_MASK = 16'h00F7
) (
  input  logic       clk,
  input  logic [7:0] addr,
  input  region_e    region,
  input  logic [3:0] bank,
  input  logic       wr_go,
  input  logic [7:0] wdata,
  output logic [7:0] rd_word
);
  localparam int SFR_NB = HAS_SFR_BANK8 ? 9 : 8;

  logic [7:0] com_mem [32];
  logic [7:0] sfr_rd  [SFR_NB];
  logic [7:0] gpr_rd  [GPR_BANKS];
  logic [7:0] gpr_off;

  assign gpr_off = addr - GPR_LO;

  always_ff @(posedge clk)
    if (wr_go && region == RG_COMMON) com_mem[addr[4:0]] <= wdata;

  for (genvar s = 0; s < SFR_NB; s++) begin : g_sfr
    logic [7:0] regs [SFR_SZ];
    always_ff @(posedge clk)
      if (wr_go && region == RG_SFR && int'(bank) == s) regs[addr[2:0]] <= wdata;
    assign sfr_rd[s] = regs[addr[2:0]];
  end

  for (genvar g = 0; g < GPR_BANKS; g++) begin : g_gpr
    if (GPR_IMPL_MASK[g]) begin : g_on
      logic [7:0] mem [GPR_SZ];
      always_ff @(posedge clk)
        if (wr_go && region == RG_GPR && int'(bank) == g) mem[gpr_off] <= wdata;
      assign gpr_rd[g] = mem[gpr_off];
    end else begin : g_off
      assign gpr_rd[g] = 8'h00;
    end
  end

  always_comb begin
    rd_word = 8'h00;
    unique case (region)
      RG_COMMON: rd_word = com_mem[addr[4:0]];
      RG_SFR:    for (int i = 0; i < SFR_NB; i++)
                   if (int'(bank) == i) rd_word = sfr_rd[i];
      RG_GPR:    for (int i = 0; i < GPR_BANKS; i++)
                   if (int'(bank) == i) rd_word = gpr_rd[i];
      default: ;
    endcase
  end
endmodule

// File: rtl/bank_mem_front.sv
module bank_mem_front
  import bmf_pkg::*;
#(
  parameter bit          HAS_SFR_BANK8 = 1'b1,
  parameter int          GPR_BANKS     = 8,
  parameter logic [15:0] GPR_IMPL_MASK = 16'h00F7,
  parameter logic [7:0]  RSVD_PATTERN  = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       ld_sfr_en,
  input  logic       ld_gpr_en,
  input  logic [3:0] bank_nib,
  output logic [7:0] rdata,
  output logic       unimpl_hit,
  output logic       rsvd_hit,
  output logic [7:0] bsr_q
);
  region_e    region;
  logic [3:0] bank;
  logic       acc_ok;
  logic       wr_go;
  logic [7:0] rd_word;

  bmf_bsr u_bsr (
    .clk(clk), .rst_n(rst_n), .ld_lo(ld_sfr_en), .ld_hi(ld_gpr_en),
    .nib(bank_nib), .bsr(bsr_q)
  );

  bmf_decode #(
    .HAS_SFR_BANK8(HAS_SFR_BANK8), .GPR_BANKS(GPR_BANKS), .GPR_IMPL_MASK(GPR_IMPL_MASK)
  ) u_dec (
    .addr(addr), .bsr(bsr_q), .access(rd_en | wr_en), .region(region),
    .bank(bank), .acc_ok(acc_ok), .unimpl(unimpl_hit), .rsvd(rsvd_hit)
  );

  assign wr_go = wr_en & acc_ok & ~rsvd_hit;

  bmf_store #(
    .HAS_SFR_BANK8(HAS_SFR_BANK8), .GPR_BANKS(GPR_BANKS), .GPR_IMPL_MASK(GPR_IMPL_MASK)
  ) u_store (
    .clk(clk), .addr(addr), .region(region), .bank(bank), .wr_go(wr_go),
    .wdata(wdata), .rd_word(rd_word)
  );

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (rsvd_hit)    rdata = RSVD_PATTERN;
      else if (acc_ok) rdata = rd_word;
    end
  end
endmodule

// File: rtl/bmf_chk.sv
module bmf_chk
  import bmf_pkg::*;
#(
  parameter logic [7:0] RSVD_PATTERN = 8'hA5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic       ld_sfr_en,
  input logic       ld_gpr_en,
  input logic [3:0] bank_nib,
  input logic [7:0] bsr_q,
  input logic [7:0] rdata,
  input logic       unimpl_hit,
  input logic       rsvd_hit,
  input region_e    region,
  input logic       wr_go
);
  assert_bsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_sfr_en && !ld_gpr_en) |=> $stable(bsr_q));

  assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sfr_en && !ld_gpr_en) |=>
      (bsr_q[3:0] == $past(bank_nib) && bsr_q[7:4] == $past(bsr_q[7:4])));

  assert_hi_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_gpr_en && !ld_sfr_en) |=>
      (bsr_q[7:4] == $past(bank_nib) && bsr_q[3:0] == $past(bsr_q[3:0])));

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unimpl_hit) |-> rdata == 8'h00);

  assert_unimpl_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_hit |-> !wr_go);

  assert_rsvd_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsvd_hit) |-> (rdata == RSVD_PATTERN && !unimpl_hit && !wr_go));

  assert_common_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_COMMON) |-> (!unimpl_hit && !rsvd_hit));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> (rdata == 8'h00 && !unimpl_hit && !rsvd_hit));
endmodule

bind bank_mem_front bmf_chk #(.RSVD_PATTERN(RSVD_PATTERN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
  .ld_sfr_en(ld_sfr_en), .ld_gpr_en(ld_gpr_en), .bank_nib(bank_nib),
  .bsr_q(bsr_q), .rdata(rdata), .unimpl_hit(unimpl_hit), .rsvd_hit(rsvd_hit),
  .region(region), .wr_go(wr_go)
);

// File: tb/bank_mem_front_tb.sv
module bank_mem_front_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       ld_sfr_en = 1'b0, ld_gpr_en = 1'b0;
  logic [3:0] bank_nib = 4'h0;
  logic [7:0] rdata, bsr_q;
  logic       unimpl_hit, rsvd_hit;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_mem_front u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .ld_sfr_en(ld_sfr_en), .ld_gpr_en(ld_gpr_en),
    .bank_nib(bank_nib), .rdata(rdata), .unimpl_hit(unimpl_hit),
    .rsvd_hit(rsvd_hit), .bsr_q(bsr_q)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic load(input bit lo, input bit hi, input logic [3:0] n);
    @(negedge clk);
    ld_sfr_en = lo; ld_gpr_en = hi; bank_nib = n;
    @(negedge clk);
    ld_sfr_en = 1'b0; ld_gpr_en = 1'b0;
  endtask

  task automatic set_bsr(input logic [3:0] hi, input logic [3:0] lo);
    load(1'b1, 1'b0, lo);
    load(1'b0, 1'b1, hi);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d,
                    output logic u, output logic r);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata; u = unimpl_hit; r = rsvd_hit;
    #1;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 bsr after reset", bsr_q, 8'h00);
    chk("R10 rdata idle", rdata, 8'h00);
    chk("R10 flags idle", {6'd0, unimpl_hit, rsvd_hit}, 8'h00);
  endtask

  task automatic t_loads;
    load(1'b1, 1'b0, 4'h5); #1 chk("R2 low nibble load", bsr_q, 8'h05);
    load(1'b0, 1'b1, 4'hA); #1 chk("R3 high nibble load", bsr_q, 8'hA5);
    load(1'b1, 1'b0, 4'h2); #1 chk("R2 high kept", bsr_q, 8'hA2);
    load(1'b1, 1'b1, 4'h7); #1 chk("R2 dual load", bsr_q, 8'h77);
  endtask

  task automatic t_common;
    logic [7:0] d; logic u, r;
    set_bsr(4'h0, 4'h0);
    wr(8'h05, 8'h11); wr(8'h1A, 8'h22); wr(8'h00, 8'h33); wr(8'h0F, 8'h44);
    set_bsr(4'hF, 4'hF);
    rd(8'h05, d, u, r); chk("R4 common 05", d, 8'h11);
    chk("R4 common no flag", {6'd0, u, r}, 8'h00);
    rd(8'h1A, d, u, r); chk("R4 common 1A", d, 8'h22);
    set_bsr(4'h3, 4'hC);
    rd(8'h00, d, u, r); chk("R4 common 00", d, 8'h33);
    rd(8'h0F, d, u, r); chk("R4 common 0F", d, 8'h44);
  endtask

  task automatic t_sfr;
    logic [7:0] d; logic u, r;
    for (int b = 0; b < 9; b++) begin
      load(1'b1, 1'b0, 4'(b));
      wr(8'h12, 8'h30 + 8'(b));
      wr(8'h17, 8'h80 + 8'(b));
    end
    for (int b = 0; b < 9; b++) begin
      load(1'b1, 1'b0, 4'(b));
      rd(8'h12, d, u, r); chk("R5 sfr bank offset 2", d, 8'h30 + 8'(b));
      rd(8'h17, d, u, r); chk("R5 sfr bank offset 7", d, 8'h80 + 8'(b));
      chk("R7 built bank no flag", {6'd0, u, r}, 8'h00);
    end
  endtask

  task automatic t_sfr_unimpl;
    logic [7:0] d; logic u, r;
    for (int b = 9; b < 15; b++) begin
      load(1'b1, 1'b0, 4'(b));
      wr(8'h12, 8'hFF);
      rd(8'h12, d, u, r);
      chk("R7 unbuilt sfr reads 00", d, 8'h00);
      chk("R7 unbuilt sfr flag", {6'd0, u, r}, 8'h02);
    end
    for (int b = 0; b < 9; b++) begin
      load(1'b1, 1'b0, 4'(b));
      rd(8'h12, d, u, r); chk("R7 write discarded", d, 8'h30 + 8'(b));
    end
  endtask

  task automatic t_rsvd;
    logic [7:0] d; logic u, r;
    load(1'b1, 1'b0, 4'hF);
    rd(8'h13, d, u, r);
    chk("R9 reserved pattern", d, 8'hA5);
    chk("R9 reserved flag only", {6'd0, u, r}, 8'h01);
    wr(8'h12, 8'h5A);
    for (int b = 0; b < 9; b++) begin
      load(1'b1, 1'b0, 4'(b));
      rd(8'h12, d, u, r); chk("R9 reserved write discarded", d, 8'h30 + 8'(b));
    end
  endtask

  task automatic t_gpr;
    logic [7:0] d; logic u, r;
    for (int b = 0; b < 8; b++) begin
      if (b == 3) continue;
      load(1'b0, 1'b1, 4'(b));
      wr(8'h20, 8'h50 + 8'(b)); wr(8'hFF, 8'h60 + 8'(b));
    end
    for (int b = 0; b < 8; b++) begin
      if (b == 3) continue;
      load(1'b0, 1'b1, 4'(b));
      rd(8'h20, d, u, r); chk("R6 gpr low offset", d, 8'h50 + 8'(b));
      rd(8'hFF, d, u, r); chk("R6 gpr high offset", d, 8'h60 + 8'(b));
    end
  endtask

  task automatic t_gpr_unimpl;
    logic [7:0] d; logic u, r;
    for (int b = 3; b < 16; b++) begin
      if (b > 3 && b < 8) continue;
      load(1'b0, 1'b1, 4'(b));
      wr(8'h20, 8'hEE);
      rd(8'h20, d, u, r);
      chk("R8 unbuilt gpr reads 00", d, 8'h00);
      chk("R8 unbuilt gpr flag", {6'd0, u, r}, 8'h02);
    end
    load(1'b0, 1'b1, 4'h2); rd(8'h20, d, u, r); chk("R8 bank2 intact", d, 8'h52);
    load(1'b0, 1'b1, 4'h4); rd(8'h20, d, u, r); chk("R8 bank4 intact", d, 8'h54);
    load(1'b0, 1'b1, 4'h0); rd(8'h20, d, u, r); chk("R8 bank0 intact", d, 8'h50);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d; logic u, r;
    load(1'b0, 1'b1, 4'h0);
    @(negedge clk);
    addr = 8'h20; wdata = 8'h99; wr_en = 1'b1; ld_gpr_en = 1'b1; bank_nib = 4'h1;
    @(negedge clk);
    wr_en = 1'b0; ld_gpr_en = 1'b0;
    rd(8'h20, d, u, r); chk("R10 write used old bank (bank1)", d, 8'h51);
    load(1'b0, 1'b1, 4'h0);
    rd(8'h20, d, u, r); chk("R10 write used old bank (bank0)", d, 8'h99);
    @(negedge clk); #1;
    chk("R10 rdata low when idle", rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loads();
    t_common();
    t_sfr();
    t_sfr_unimpl();
    t_rsvd();
    t_gpr();
    t_gpr_unimpl();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule